// File: doc/BRIEF.md
# Multidrop Address-Wakeup Receiver

This block is the character-level front end of a serial receiver used on a shared multidrop line. One master talks to up to 256 slave stations. Each frame starts with an 8-bit address character, and a block of data characters follows it. An address/data flag travels with every character in the bit slot that normally carries parity: 1 marks an address and 0 marks data. The block takes characters that are already deserialized, each with that flag bit. It decides whether to keep each character, loads the ones it keeps into a holding register, and reports them through a ready bit, a gated interrupt and an overrun flag.

When multidrop mode is on and the local receiver is disabled, the block still watches every character on the line. Address characters get through and wake the CPU. Software compares the address with its own station address. If they match, software enables the receiver so that the data characters that follow are kept. A station that is not addressed leaves its receiver disabled, drops all data characters and sees only the next address. When multidrop mode is off, the block is a plain receiver: it keeps characters only while enabled and ignores the flag bit.

All inputs are sampled on the rising clock edge. Every status output is registered, except the interrupt, which is a gated copy of the registered ready bit.

Top module: `mdrx_wakeup`

## Requirements
- R1: After reset, rxReady, overrun, lastFlag and rxIrq are 0 and rdData is all zeros.
- R2: With multidropEn=0, a character (charValid=1) is kept only when rxEnable=1. The charFlag input has no effect, and lastFlag reads 0 after any kept character.
- R3: With multidropEn=1 and rxEnable=0, a character with charFlag=1 (address) is kept: the next edge loads it into rdData, sets rxReady and sets lastFlag to 1.
- R4: With multidropEn=1 and rxEnable=0, a character with charFlag=0 (data) is dropped: rxReady, rdData, lastFlag and overrun keep their values and no error is raised.
- R5: With multidropEn=1 and rxEnable=1, both address and data characters are kept, and lastFlag reports the flag of the last kept character (1 = address, 0 = data).
- R6: rxIrq equals rxReady AND rxIntEn at all times.
- R7: A rdStrobe with no kept character in the same cycle clears rxReady and overrun at the next edge. A rdStrobe in the same cycle as a kept character loads the new character, leaves rxReady at 1 and does not set overrun.
- R8: A character kept while rxReady is 1, with no rdStrobe in that cycle, sets overrun and overwrites rdData with the new character. Overrun stays set until the next rdStrobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| charValid | input | 1 | A deserialized character is present this cycle |
| charData | input | 8 | Character value |
| charFlag | input | 1 | Address/data flag from the parity slot (1 = address) |
| multidropEn | input | 1 | Multidrop wake-up mode select |
| rxEnable | input | 1 | Local receiver enable |
| rxIntEn | input | 1 | Receive interrupt enable |
| rdStrobe | input | 1 | CPU read of the data port |
| rxReady | output | 1 | A kept character is waiting |
| rxIrq | output | 1 | Receive interrupt |
| rdData | output | 8 | Held character |
| lastFlag | output | 1 | Flag of the last kept character |
| overrun | output | 1 | A character was kept while one was still waiting |

## Verification
The bench runs every combination of mode, enable, flag, interrupt enable, a pre-loaded holding register and a read in the same cycle as the character. An expected-state model built from the requirements is updated step by step as the bench runs. The most likely faults are a dropped data character that still sets ready or overwrites the held byte, and an address character that is lost while the receiver is disabled (a station that never wakes). The bench also targets a flag that leaks through in normal mode, a read that collides with a new character and wrongly clears ready or raises overrun, and an interrupt that fires while it is masked.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;
  typedef struct packed {
    logic load;
    logic flagVal;
    logic setReady;
    logic clrReady;
    logic setOvr;
    logic clrOvr;
  } mdrxStrobes_t;
endpackage

// File: rtl/mdrx_ctrl.sv
module mdrx_ctrl
  import mdrx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         charValid,
  input  logic         charFlag,
  input  logic         multidropEn,
  input  logic         rxEnable,
  input  logic         rdStrobe,
  output mdrxStrobes_t strobes,
  output logic         rxReady,
  output logic         overrun
);
  logic accept;
  logic readyQ, ovrQ;

  // keep when enabled, or when an address arrives in multidrop mode
  assign accept = charValid & (rxEnable | (multidropEn & charFlag));

  always_comb begin
    strobes.load     = accept;
    strobes.flagVal  = charFlag & multidropEn;
    strobes.setReady = accept;
    strobes.clrReady = rdStrobe & ~accept;
    strobes.setOvr   = accept & readyQ & ~rdStrobe;
    strobes.clrOvr   = rdStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      ovrQ   <= 1'b0;
    end else begin
      if (strobes.setReady)      readyQ <= 1'b1;
      else if (strobes.clrReady) readyQ <= 1'b0;
      if (strobes.clrOvr)        ovrQ   <= 1'b0;
      else if (strobes.setOvr)   ovrQ   <= 1'b1;
    end
  end

  assign rxReady = readyQ;
  assign overrun = ovrQ;

  AST_ADDR_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && multidropEn && charFlag) |=> rxReady); // R3
  AST_DATA_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && multidropEn && !rxEnable && !charFlag && !rdStrobe)
      |=> ($stable(rxReady) && $stable(overrun))); // R4
  AST_NORMAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !multidropEn && !rxEnable && !rdStrobe)
      |=> ($stable(rxReady) && $stable(overrun))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !charValid) |=> (!rxReady && !overrun)); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && charValid && rxEnable && !rdStrobe) |=> overrun); // R8
endmodule

// File: rtl/mdrx_datapath.sv
module mdrx_datapath
  import mdrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdrxStrobes_t      strobes,
  input  logic [DATA_W-1:0] charData,
  output logic [DATA_W-1:0] rdData,
  output logic              lastFlag
);
  logic [DATA_W-1:0] dataQ;
  logic              flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      flagQ <= 1'b0;
    end else if (strobes.load) begin
      dataQ <= charData;
      flagQ <= strobes.flagVal;
    end
  end

  assign rdData   = dataQ;
  assign lastFlag = flagQ;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(rdData) && $stable(lastFlag))); // R4
endmodule

// File: rtl/mdrx_wakeup.sv
module mdrx_wakeup
  import mdrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              charFlag,
  input  logic              multidropEn,
  input  logic              rxEnable,
  input  logic              rxIntEn,
  input  logic              rdStrobe,
  output logic              rxReady,
  output logic              rxIrq,
  output logic [DATA_W-1:0] rdData,
  output logic              lastFlag,
  output logic              overrun
);
  mdrxStrobes_t strobes;

  mdrx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charFlag(charFlag),
    .multidropEn(multidropEn), .rxEnable(rxEnable), .rdStrobe(rdStrobe),
    .strobes(strobes), .rxReady(rxReady), .overrun(overrun)
  );

  mdrx_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .charData(charData),
    .rdData(rdData), .lastFlag(lastFlag)
  );

  assign rxIrq = rxReady & rxIntEn;

  AST_NORMAL_NOFLAG: assert property (@(posedge clk) disable iff (!rstN)
    (charValid && !multidropEn && rxEnable) |=> !lastFlag); // R2
endmodule

// File: tb/mdrx_wakeup_tb.sv
module mdrx_wakeup_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic charValid = 0, charFlag = 0, multidropEn = 0, rxEnable = 0;
  logic rxIntEn = 0, rdStrobe = 0;
  logic [7:0] charData = '0;
  logic rxReady, rxIrq, lastFlag, overrun;
  logic [7:0] rdData;

  int nTests = 0, nFail = 0;
  logic mReady = 0, mOvr = 0, mFlag = 0;
  logic [7:0] mData = '0;

  always #4 clk = ~clk;

  mdrx_wakeup dut_i (
    .clk(clk), .rstN(rstN), .charValid(charValid), .charData(charData),
    .charFlag(charFlag), .multidropEn(multidropEn), .rxEnable(rxEnable),
    .rxIntEn(rxIntEn), .rdStrobe(rdStrobe), .rxReady(rxReady), .rxIrq(rxIrq),
    .rdData(rdData), .lastFlag(lastFlag), .overrun(overrun)
  );

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    chk(tag, "ready", {7'd0, rxReady}, {7'd0, mReady});
    chk(tag, "data", rdData, mData);
    chk(tag, "flag", {7'd0, lastFlag}, {7'd0, mFlag});
    chk("R8", "overrun", {7'd0, overrun}, {7'd0, mOvr});
    chk("R6", "irq", {7'd0, rxIrq}, {7'd0, mReady & rxIntEn});
  endtask

  // drive at negedge, model the edge, check at the next negedge
  task automatic step(logic v, logic [7:0] d, logic f, logic m, logic e,
                      logic ie, logic rd, string tag);
    logic acc;
    charValid = v; charData = d; charFlag = f; multidropEn = m;
    rxEnable = e; rxIntEn = ie; rdStrobe = rd;
    acc = v & (e | (m & f));
    if (rd) mOvr = 1'b0;
    else if (acc && mReady) mOvr = 1'b1;
    if (acc) begin
      mData = d; mFlag = f & m; mReady = 1'b1;
    end else if (rd) mReady = 1'b0;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");
    for (int idx = 0; idx < 64; idx++) begin
      logic m, e, f, ie, pre, rds;
      string tag;
      m = idx[0]; e = idx[1]; f = idx[2]; ie = idx[3]; pre = idx[4]; rds = idx[5];
      tag = !m ? "R2" : (!e ? (f ? "R3" : "R4") : "R5");
      if (rds) tag = "R7";
      step(1'b0, 8'h00, 1'b0, m, e, ie, 1'b1, "R7");
      if (pre) step(1'b1, 8'(idx * 13 + 5), 1'b1, m, 1'b1, ie, 1'b0, "R5");
      step(1'b1, 8'(idx * 37 + 11), f, m, e, ie, rds, tag);
      step(1'b0, 8'h00, 1'b0, m, e, ie, 1'b0, "R6");
    end
    // drop in multidrop while a byte is held, then two addresses in a row
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7");
    step(1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
    step(1'b1, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
    step(1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule